// File: doc/BRIEF.md
# Instruction namespace control register

This block holds the 32-bit control word that selects the instruction namespace: a set of hidden bits that the instruction decoder sees alongside every fetched opcode. Bit 0 picks the mode. With bit 0 clear the word describes the native instruction set: a binary page for the 16-bit opcode space, a byte-order bit and a custom byte. With bit 0 set, bits 7:1 are a binary index that names exactly one foreign architecture.

Software reaches the register through a control-register style port: an address, a write enable and write data, plus a read-data output. Each write is checked against build-time masks that list the supported pages, foreign indices, custom bits and byte orders. A write that passes replaces the register. A write that fails leaves the register as it was and raises a trap strobe in the same cycle, so that an emulation layer can take over. The register never stores a substitute value. The decoded fields drive the decoder directly.

Top module: `nsctl_reg`

## Requirements
- R1: After reset the register holds 0. This means native mode, page 0, little-endian and custom byte 0. All decoded outputs are 0, and a read at `CSR_ADDR` returns 0.
- R2: A legal write is one where `csr_we` is 1, `csr_addr` equals `CSR_ADDR` and the data passes R5 to R8. It updates the register at the next rising clock edge, without a trap. A write is ignored and no trap is raised when `csr_we` is 0 or when the address differs.
- R3: In native mode (bit 0 = 0) the outputs decode as follows: `ns_page` = bits 4:1, `ns_big_endian` = bit 6 (1 = big-endian), `ns_custom` = bits 31:24. `ns_arch` is 0.
- R4: In foreign mode (bit 0 = 1) `ns_arch` = bits 7:1. Bit 7 set marks a custom architecture; bit 7 clear marks one of the 64 official slots. `ns_page`, `ns_big_endian` and `ns_custom` are 0.
- R5: In native mode a write that sets bit 5 or any of bits 23:7 is illegal. A write that sets a bit in 31:24 whose position is clear in `CUSTOM_MASK` is also illegal.
- R6: In native mode a write is illegal when `PAGE_MASK` has a 0 at the page value in bits 4:1. Page 0 is always legal, whatever the mask says.
- R7: In foreign mode a write is illegal when any of bits 31:8 is set, or when `FOREIGN_MASK` has a 0 at the index in bits 7:1.
- R8: In native mode a write with bit 6 = 1 is illegal when `BE_OK` is 0.
- R9: An illegal write (enable high, address match, data failing R5 to R8) leaves the register unchanged. `trap_illegal` is 1 only in the cycle in which such a write is presented, and 0 in every other cycle.
- R10: `csr_rdata` shows the stored register value while `csr_addr` equals `CSR_ADDR`, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_addr | input | 12 | Register address for reads and writes |
| csr_we | input | 1 | Write enable |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data: the register when the address matches, else 0 |
| ns_foreign | output | 1 | Foreign-architecture mode selected |
| ns_page | output | 4 | Native 16-bit opcode page (0 in foreign mode) |
| ns_big_endian | output | 1 | Native big-endian operation |
| ns_arch | output | 7 | Foreign architecture index (0 in native mode) |
| ns_custom | output | 8 | Native custom byte (0 in foreign mode) |
| trap_illegal | output | 1 | Illegal-write trap, same cycle as the write |

## Verification
A corrupted register shows up at the ports on the first read after it happens. It can appear as a read value the reference model does not expect, or as decoded fields that disagree with the mode bit, for example a nonzero page while foreign mode is set. A missed or spurious legality decision shows up at once, because `trap_illegal` is combinational in the write cycle. It also shows one cycle later: an illegal value has been stored, or a legal one has been lost. The bench therefore compares the trap in the write cycle and reads the register and all fields back in the following cycle.

// File: rtl/nsctl_reg.sv
module nsctl_reg #(
  parameter logic [11:0]  CSR_ADDR     = 12'h7C0,
  parameter logic [15:0]  PAGE_MASK    = 16'h0106,
  parameter logic [127:0] FOREIGN_MASK = 128'h0000_0000_0000_0003_0000_0000_0001_000F,
  parameter logic [7:0]   CUSTOM_MASK  = 8'h0F,
  parameter logic         BE_OK        = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] csr_addr,
  input  logic        csr_we,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output logic        ns_foreign,
  output logic [3:0]  ns_page,
  output logic        ns_big_endian,
  output logic [6:0]  ns_arch,
  output logic [7:0]  ns_custom,
  output logic        trap_illegal
);
  localparam logic [15:0] PAGES_OK = PAGE_MASK | 16'h0001;

  logic [31:0] ns_q;
  logic        hit, wr, rv_ok, fa_ok, legal;

  assign hit = csr_addr == CSR_ADDR;
  assign wr  = csr_we && hit;

  assign rv_ok = !csr_wdata[5] && (csr_wdata[23:7] == '0) &&
                 ((csr_wdata[31:24] & ~CUSTOM_MASK) == '0) &&
                 PAGES_OK[csr_wdata[4:1]] &&
                 (BE_OK || !csr_wdata[6]);
  assign fa_ok = (csr_wdata[31:8] == '0) && FOREIGN_MASK[csr_wdata[7:1]];
  assign legal = csr_wdata[0] ? fa_ok : rv_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          ns_q <= '0;
    else if (wr && legal) ns_q <= csr_wdata;

  assign trap_illegal  = wr && !legal;
  assign csr_rdata     = hit ? ns_q : '0;
  assign ns_foreign    = ns_q[0];
  assign ns_page       = ns_q[0] ? 4'd0 : ns_q[4:1];
  assign ns_big_endian = !ns_q[0] && ns_q[6];
  assign ns_arch       = ns_q[0] ? ns_q[7:1] : 7'd0;
  assign ns_custom     = ns_q[0] ? 8'd0 : ns_q[31:24];
endmodule

module nsctl_reg_chk #(
  parameter logic [11:0] CSR_ADDR  = 12'h7C0,
  parameter logic [15:0] PAGE_MASK = 16'h0106
) (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] csr_addr,
  input logic        csr_we,
  input logic [31:0] ns_q,
  input logic        ns_foreign,
  input logic [3:0]  ns_page,
  input logic        ns_big_endian,
  input logic        trap_illegal
);
  localparam logic [15:0] PAGES_OK = PAGE_MASK | 16'h0001;

  AST_TRAP_KEEPS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_illegal |=> $stable(ns_q)); // R9
  AST_TRAP_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_illegal |-> (csr_we && csr_addr == CSR_ADDR)); // R9
  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_we && csr_addr == CSR_ADDR) |=> $stable(ns_q)); // R2
  AST_RV_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !ns_q[0] |-> (ns_q[23:7] == '0 && !ns_q[5])); // R5
  AST_RV_PAGE_SUPPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    !ns_q[0] |-> PAGES_OK[ns_q[4:1]]); // R6
  AST_FOREIGN_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ns_q[0] |-> ns_q[31:8] == '0); // R7
  AST_FOREIGN_FIELDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ns_foreign |-> (ns_page == '0 && !ns_big_endian)); // R4
endmodule

bind nsctl_reg nsctl_reg_chk #(.CSR_ADDR(CSR_ADDR), .PAGE_MASK(PAGE_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we), .ns_q(ns_q),
  .ns_foreign(ns_foreign), .ns_page(ns_page), .ns_big_endian(ns_big_endian),
  .trap_illegal(trap_illegal));

// File: tb/test_nsctl_reg.sv
`timescale 1ns/1ps
module test_nsctl_reg;
  localparam logic [11:0]  A  = 12'h7C0;
  localparam logic [15:0]  PM = 16'h0106;
  localparam logic [127:0] FM = 128'h0000_0000_0000_0003_0000_0000_0001_000F;
  localparam logic [7:0]   CM = 8'h0F;

  logic clk = 0, rst_n = 0, we = 0, trap, nf, nbe;
  logic [11:0] addr = A;
  logic [31:0] wdata = 0, rdata, model = 0;
  logic [3:0] npg;
  logic [6:0] narch;
  logic [7:0] ncus;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nsctl_reg i_nsctl_reg (.clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_we(we),
    .csr_wdata(wdata), .csr_rdata(rdata), .ns_foreign(nf), .ns_page(npg),
    .ns_big_endian(nbe), .ns_arch(narch), .ns_custom(ncus), .trap_illegal(trap));

  function automatic bit legal(input logic [31:0] d);
    if (d[0]) return d[31:8] == 0 && FM[d[7:1]];
    if (d[5] || d[23:7] != 0) return 0;
    if ((d[31:24] & ~CM) != 0) return 0;
    return d[4:1] == 0 || PM[d[4:1]];
  endfunction

  function automatic logic [20:0] fields(input logic [31:0] m);
    if (m[0]) return {1'b1, 4'd0, 1'b0, m[7:1], 8'd0};
    return {1'b0, m[4:1], m[6], 7'd0, m[31:24]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic [11:0] a, input logic w, input logic [31:0] d, input string req);
    bit et;
    @(negedge clk);
    addr = a; we = w; wdata = d;
    #1;
    et = w && a == A && !legal(d);
    check(trap == et, {req, " trap"}, {31'd0, trap}, {31'd0, et});
    @(posedge clk);
    if (w && a == A && !et) model = d;
    @(negedge clk);
    we = 0; addr = A;
    #1;
    check(rdata == model, {req, " readback"}, rdata, model);
    check({nf, npg, nbe, narch, ncus} == fields(model), model[0] ? "R4 fields" : "R3 fields",
          {11'd0, nf, npg, nbe, narch, ncus}, {11'd0, fields(model)});
    check(trap == 0, "R9 trap idle", {31'd0, trap}, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #12 rst_n = 1;
    @(negedge clk); #1;
    check(rdata == 0, "R1 reset value", rdata, 0);
    check({nf, npg, nbe, narch, ncus} == 0, "R1 reset fields", {11'd0, nf, npg, nbe, narch, ncus}, 0);

    access(A, 1, 32'h0F00_0044, "R3 page2 be custom");
    access(A, 1, 32'h0000_0000, "R6 page0 always");
    access(A, 1, 32'h0000_0006, "R6 page3 unsupported");
    access(A, 1, 32'h0000_0010, "R6 page8 supported");
    access(A, 1, 32'h0000_0020, "R5 bit5 reserved");
    access(A, 1, 32'h0080_0002, "R5 bit23 reserved");
    access(A, 1, 32'h0000_0082, "R5 bit7 reserved");
    access(A, 1, 32'h1000_0002, "R5 custom bit outside mask");
    access(A, 1, 32'h0000_0007, "R4 foreign index3");
    access(A, 1, 32'h0000_0081, "R4 foreign custom index64");
    access(A, 1, 32'h0000_0101, "R7 foreign high bit");
    access(A, 1, 32'h0000_0009, "R7 foreign index4 unsupported");
    access(A, 1, 32'h0000_0040, "R8 big endian allowed");
    access(A + 1, 1, 32'h0000_0002, "R2 wrong address");
    access(A, 0, 32'h0000_0002, "R2 enable low");

    @(negedge clk); addr = A + 12'h3; #1;
    check(rdata == 0, "R10 read other address", rdata, 0);
    addr = A; #1;
    check(rdata == model, "R10 read own address", rdata, model);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] d;
      int k;
      k = $urandom % 8;
      d = $urandom;
      if (k < 3) d = {d[31:24] & CM, 16'd0, 1'b0, d[6], 1'b0, d[4:1], 1'b0};
      else if (k < 5) d = {24'd0, d[7:1], 1'b1};
      else if (k == 5) d = {24'd0, d[7], 6'd0, 1'b1};
      access(($urandom % 6 == 0) ? A ^ 12'h1 : A, ($urandom % 5) != 0, d,
             legal(d) ? "R2 random legal" : "R9 random illegal");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1;
    $finish;
  end
endmodule